// File: doc/BRIEF.md
# Four-Bit Bit-Slice ALU with Condition Flags

This block is a purely combinational arithmetic-logic unit. It is built from a row of identical one-bit slices. Each slice holds a full adder, a four-way result selector and an optional inverter on its B input. The block has no clock and no reset: the outputs follow the operands and the two-bit function code after a settling delay.

A two-bit function code chooses bitwise AND, bitwise OR, addition or subtraction. Subtraction inverts B in every slice and forces the carry into bit 0 high. At the ALU level, a four-bit condition nibble is formed next to the result. From most to least significant it carries Carry, oVerflow, Negative and Zero.

The width is a parameter and defaults to four bits. The carry and overflow flags always come from the adder chain. When a logic operation is selected, they therefore describe the sum A+B.

Top module: `slice_alu`

## Requirements
- R1: With fn = 2'b00, `y` equals `a & b`.
- R2: With fn = 2'b01, `y` equals `a | b`.
- R3: With fn = 2'b10, `y` equals the low WIDTH bits of `a + b`.
- R4: With fn = 2'b11, `y` equals the low WIDTH bits of `a + ~b + 1`. The carry into bit 0 is 1 for this code only.
- R5: `ccr` is packed as {C, V, N, Z}, with C at bit 3 and Z at bit 0.
- R6: C (ccr[3]) is the carry out of the most significant slice.
- R7: V (ccr[2]) is the carry out of the top slice XOR the carry into it. This is signed overflow of the adder operation.
- R8: N (ccr[1]) equals the most significant bit of `y`.
- R9: Z (ccr[0]) is 1 exactly when every bit of `y` is 0.
- R10: For fn = 2'b00 and 2'b01, C and V are those of `a + b` with carry-in 0, although `y` shows the logic result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| fn | input | 2 | Function code: 00 AND, 01 OR, 10 add, 11 subtract |
| y | output | WIDTH | Selected result |
| ccr | output | 4 | Condition nibble {C, V, N, Z} |

## Verification
The bench instantiates the block at its default WIDTH of 4. At that width the operand space is small enough to sweep all 1024 combinations of a, b and fn against an independent arithmetic model. This exhaustive sweep reaches every carry pattern, every signed overflow at both ends of the range, and the zero result under every function code. A vector table runs first and pins down the worked cases: zero minus zero, and -8 combined with 1 under each function. It also checks AND and OR operands whose sum carries out or overflows.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_OR  = 2'b01,
        FN_ADD = 2'b10,
        FN_SUB = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } ccr_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/sel4_cell.sv
module sel4_cell (
    input  logic [1:0] sel,
    input  logic       d0,
    input  logic       d1,
    input  logic       d2,
    input  logic       d3,
    output logic       q
);
    always_comb begin
        unique case (sel)
            2'b00:   q = d0;
            2'b01:   q = d1;
            2'b10:   q = d2;
            default: q = d3;
        endcase
    end
endmodule

// File: rtl/alu_bit.sv
module alu_bit (
    input  logic [1:0] fn,
    input  logic       ai,
    input  logic       bi,
    input  logic       cin,
    output logic       ri,
    output logic       cout
);
    import slice_alu_pkg::*;

    logic b_eff;
    logic sum_bit;

    // B is inverted locally when the code asks for subtraction
    always_comb b_eff = bi ^ (fn == FN_SUB);

    fa_cell u_fa (
        .x (ai),
        .y (b_eff),
        .ci(cin),
        .s (sum_bit),
        .co(cout)
    );

    sel4_cell u_sel (
        .sel(fn),
        .d0 (ai & bi),
        .d1 (ai | bi),
        .d2 (sum_bit),
        .d3 (sum_bit),
        .q  (ri)
    );
endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y,
    output logic [3:0]       ccr
);
    import slice_alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] res;
    ccr_t             flags;

    // Carry into bit 0 is set for subtraction only (R4)
    always_comb carry[0] = (fn == FN_SUB);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_bit u_bit (
            .fn  (fn),
            .ai  (a[i]),
            .bi  (b[i]),
            .cin (carry[i]),
            .ri  (res[i]),
            .cout(carry[i+1])
        );
    end

    always_comb begin
        flags.c = carry[WIDTH];               // R6
        flags.v = carry[WIDTH] ^ carry[MSB];  // R7
        flags.n = res[MSB];                   // R8
        flags.z = (res == '0);                // R9
        y       = res;
        ccr     = flags;                      // R5 packing
    end

    // Arithmetic cross-checks of the slice chain
    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    always_comb begin
        ref_add = {1'b0, a} + {1'b0, b};
        ref_sub = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        if (fn == FN_AND) begin
            p_and_result_r1: assert (res == (a & b))
                else $error("R1 AND result mismatch");
        end
        if (fn == FN_OR) begin
            p_or_result_r2: assert (res == (a | b))
                else $error("R2 OR result mismatch");
        end
        if (fn == FN_ADD) begin
            p_add_sum_r3: assert ({carry[WIDTH], res} == ref_add)
                else $error("R3 add sum mismatch");
        end
        if (fn == FN_SUB) begin
            p_sub_sum_r4: assert ({carry[WIDTH], res} == ref_sub)
                else $error("R4 subtract mismatch");
        end
        if (fn != FN_SUB) begin
            p_logic_carry_r10: assert (carry[WIDTH] == ref_add[WIDTH])
                else $error("R10 carry not from a+b");
        end
        if (fn == FN_ADD) begin
            p_overflow_sign_r7: assert (flags.v ==
                ((a[MSB] == b[MSB]) && (res[MSB] != a[MSB])))
                else $error("R7 overflow mismatch");
        end
    end
endmodule

// File: tb/slice_alu_test.sv
module slice_alu_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [1:0]   fn = 2'b00;
    logic [W-1:0] y;
    logic [3:0]   ccr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    slice_alu #(.WIDTH(W)) uut (
        .a  (a),
        .b  (b),
        .fn (fn),
        .y  (y),
        .ccr(ccr)
    );

    // {fn, a, b, expected y, expected ccr}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {2'b00, 4'h0, 4'h0, 4'h0, 4'h1},
        {2'b01, 4'h0, 4'h0, 4'h0, 4'h1},
        {2'b10, 4'h0, 4'h0, 4'h0, 4'h1},
        {2'b11, 4'h0, 4'h0, 4'h0, 4'h9},
        {2'b00, 4'h8, 4'h1, 4'h0, 4'h1},
        {2'b01, 4'h8, 4'h1, 4'h9, 4'h2},
        {2'b10, 4'h8, 4'h1, 4'h9, 4'h2},
        {2'b11, 4'h8, 4'h1, 4'h7, 4'hC},
        {2'b10, 4'hF, 4'h1, 4'h0, 4'h9},
        {2'b00, 4'hF, 4'h1, 4'h1, 4'h8},
        {2'b10, 4'h7, 4'h1, 4'h8, 4'h6},
        {2'b01, 4'h7, 4'h1, 4'h7, 4'h4}
    };

    function automatic string res_tag(input logic [1:0] f);
        case (f)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [W+5:0] model(input logic [1:0] f,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] z);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        s = (f == 2'b11) ? ({1'b0, x} + {1'b0, ~z} + 1) : ({1'b0, x} + {1'b0, z});
        c = s[W];
        v = (f == 2'b11) ? ((x[W-1] != z[W-1]) && (s[W-1] != x[W-1]))
                         : ((x[W-1] == z[W-1]) && (s[W-1] != x[W-1]));
        case (f)
            2'b00:   r = x & z;
            2'b01:   r = x | z;
            default: r = s[W-1:0];
        endcase
        return {r, c, v, r[W-1], (r == '0), 2'b00};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h",
                     tag, fn, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] f, input logic [W-1:0] x,
                         input logic [W-1:0] z);
        @(posedge clk);
        #1;
        fn = f; a = x; b = z;
        @(negedge clk);
    endtask

    initial begin
        // directed table: results per function, packed flags (R5)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:16], VEC[i][15:12], VEC[i][11:8]);
            check(res_tag(VEC[i][17:16]), y, VEC[i][7:4]);
            check("R5", ccr, VEC[i][3:0]);
        end
        // exhaustive sweep against the model
        for (int f = 0; f < 4; f++) begin
            for (int x = 0; x < 16; x++) begin
                for (int z = 0; z < 16; z++) begin
                    logic [W+5:0] e;
                    apply(f[1:0], x[W-1:0], z[W-1:0]);
                    e = model(f[1:0], x[W-1:0], z[W-1:0]);
                    check(res_tag(f[1:0]), y, e[W+5:6]);
                    check((f < 2) ? "R10" : "R6", {3'b000, ccr[3]}, {3'b000, e[5]});
                    check((f < 2) ? "R10" : "R7", {3'b000, ccr[2]}, {3'b000, e[4]});
                    check("R8", {3'b000, ccr[1]}, {3'b000, e[3]});
                    check("R9", {3'b000, ccr[0]}, {3'b000, e[2]});
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule